// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block is a buffered reservation station that sits between dispatch and one group of identical execution units. Each dispatched micro-op carries a destination tag, two source tags with readiness flags and an execution latency. The block keeps the micro-op until both sources are available and then issues it, oldest first, to a free unit of the group. Units are taken in round-robin order. After the carried latency has run out, the micro-op leaves through a write-back port. That port announces its destination tag to retire and also wakes any dependent entries. Dependency discovery happens upstream. A dispatch stage and a result bus outside the block supply the tags and wakeups.

Each slot runs its own state machine with five states. FREE is an empty slot. WAIT means a source is missing. READY means it is eligible for issue. ISSUED means it is counting down its latency. DONE means it has finished but lost the write-back port to an older entry. The transitions are:
- alloc_wait: FREE to WAIT, on dispatch with a missing source.
- alloc_ready: FREE to READY, on dispatch with both sources present.
- wakeup: WAIT to READY, once both sources are present.
- grant: READY to ISSUED.
- finish_wb: ISSUED to FREE, when the count ends and the port is won.
- finish_hold: ISSUED to DONE, when the count ends and the port is lost.
- drain: DONE to FREE, when the port is won.

The block reports its occupancy and the number of executing entries for statistics.

Top module: `issue_sched`

## Requirements
- R1: After reset, `full` and `issue_valid` and `wb_valid` are 0, and `occupancy` and `inflight` are 0.
- R2: A dispatched micro-op enters WAIT if either source readiness flag is 0 and no wakeup in the same cycle matches that source tag; otherwise it enters READY. It is never offered for issue in its dispatch cycle. A micro-op that enters READY with free units is offered (`issue_valid`=1 with its tag) in the cycle after the dispatch edge.
- R3: A source becomes available when `wake_valid` with a matching `wake_tag` is seen, or when a write-back broadcasts a matching `wb_tag`. This includes a wakeup in the dispatch cycle. An entry in WAIT moves to READY at the edge where its last source becomes available. A non-matching tag has no effect.
- R4: The offered micro-op is the oldest READY entry by dispatch order. A younger READY entry issues ahead of an older entry that is still in WAIT.
- R5: The issue unit is the first non-busy unit (`unit_busy` bit 0 means free) at or after a round-robin pointer. The pointer starts at unit 0 and moves to one past the unit used after each issue. No issue is offered while all units are busy. At most one micro-op issues per cycle.
- R6: A micro-op issued in cycle c with latency L (L=0 is treated as 1) presents `wb_valid` with its tag in cycle c+L, when it has no competitor for the port. Its slot is freed at the end of the write-back cycle.
- R7: When several entries finish in the same cycle, one write-back per cycle is presented, oldest first. The others hold in DONE and follow in later cycles.
- R8: `full` is 1 when all DEPTH slots are occupied. A dispatch presented while `full` is 1 is dropped and never issues.
- R9: `occupancy` counts non-FREE slots. `inflight` counts slots in ISSUED or DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dst | input | TAGW | Destination tag of the dispatched micro-op |
| disp_src0_tag | input | TAGW | First source tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | TAGW | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_lat | input | LATW | Execution latency in cycles (0 acts as 1) |
| full | output | 1 | No free slot; dispatch is dropped |
| wake_valid | input | 1 | External result-tag wakeup |
| wake_tag | input | TAGW | Tag being woken |
| unit_busy | input | NUNITS | Per-unit busy flags |
| issue_valid | output | 1 | A micro-op is issued this cycle |
| issue_unit | output | UW | Unit receiving the issued micro-op |
| issue_tag | output | TAGW | Destination tag of the issued micro-op |
| wb_valid | output | 1 | Write-back and retire notification |
| wb_tag | output | TAGW | Tag being written back, also broadcast as a wakeup |
| occupancy | output | CW | Number of occupied slots |
| inflight | output | CW | Number of slots in ISSUED or DONE |

## Verification
The latency path is swept over every latency value, L=0 included. This separates a correct down-counter from an off-by-one count or a dropped zero case. Wakeup is driven three ways: by an external tag, by a write-back broadcast, and in the same cycle as dispatch, together with non-matching tags. This tells apart the readiness paths and the bypass. Issue order is exercised with all units busy while older waiting and younger ready entries pile up, then with each single unit busy in turn. This exposes wrong age selection and pointer mistakes. Filling all slots, presenting one more dispatch, and forcing two completions into the same cycle exercise the full, drop and write-back arbitration corners.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_READY  = 3'd2,
        ST_ISSUED = 3'd3,
        ST_DONE   = 3'd4
    } slot_state_t;
endpackage

// File: rtl/sched_slot.sv
module sched_slot
    import sched_pkg::*;
#(
    parameter int TAGW = 4,
    parameter int LATW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_i,
    input  logic [TAGW-1:0] a_dst_i,
    input  logic [TAGW-1:0] a_s0_tag_i,
    input  logic            a_s0_rdy_i,
    input  logic [TAGW-1:0] a_s1_tag_i,
    input  logic            a_s1_rdy_i,
    input  logic [LATW-1:0] a_lat_i,
    input  logic            wk_v_i,
    input  logic [TAGW-1:0] wk_tag_i,
    input  logic            bc_v_i,
    input  logic [TAGW-1:0] bc_tag_i,
    input  logic            iss_gnt_i,
    input  logic            wb_gnt_i,
    output logic            used_o,
    output logic            exec_o,
    output logic            iss_req_o,
    output logic            wb_req_o,
    output logic [TAGW-1:0] dst_o
);
    slot_state_t     st, st_n;
    logic            s0_ok, s1_ok, s0_n, s1_n;
    logic [LATW-1:0] cnt, cnt_n;
    logic [TAGW-1:0] dst_q, s0_tag, s1_tag;
    logic [LATW-1:0] lat_q;

    function automatic logic tag_hit(input logic [TAGW-1:0] t);
        return (wk_v_i && (wk_tag_i == t)) || (bc_v_i && (bc_tag_i == t));
    endfunction

    // next-state logic
    always_comb begin
        st_n  = st;
        s0_n  = s0_ok;
        s1_n  = s1_ok;
        cnt_n = cnt;
        unique case (st)
            ST_FREE: begin
                if (alloc_i) begin
                    s0_n = a_s0_rdy_i || tag_hit(a_s0_tag_i);
                    s1_n = a_s1_rdy_i || tag_hit(a_s1_tag_i);
                    st_n = (s0_n && s1_n) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                s0_n = s0_ok || tag_hit(s0_tag);
                s1_n = s1_ok || tag_hit(s1_tag);
                if (s0_n && s1_n) st_n = ST_READY;
            end
            ST_READY: begin
                if (iss_gnt_i) begin
                    st_n  = ST_ISSUED;
                    cnt_n = (lat_q == '0) ? LATW'(1) : lat_q;
                end
            end
            ST_ISSUED: begin
                if (cnt == LATW'(1)) st_n = wb_gnt_i ? ST_FREE : ST_DONE;
                else                 cnt_n = cnt - LATW'(1);
            end
            ST_DONE: begin
                if (wb_gnt_i) st_n = ST_FREE;
            end
            default: st_n = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_FREE;
            s0_ok <= 1'b0;
            s1_ok <= 1'b0;
            cnt   <= '0;
        end else begin
            st    <= st_n;
            s0_ok <= s0_n;
            s1_ok <= s1_n;
            cnt   <= cnt_n;
        end
    end

    // payload captured on allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            s0_tag <= '0;
            s1_tag <= '0;
            lat_q  <= '0;
        end else if (alloc_i && st == ST_FREE) begin
            dst_q  <= a_dst_i;
            s0_tag <= a_s0_tag_i;
            s1_tag <= a_s1_tag_i;
            lat_q  <= a_lat_i;
        end
    end

    // outputs
    always_comb begin
        used_o    = (st != ST_FREE);
        exec_o    = (st == ST_ISSUED) || (st == ST_DONE);
        iss_req_o = (st == ST_READY);
        wb_req_o  = ((st == ST_ISSUED) && (cnt == LATW'(1))) || (st == ST_DONE);
        dst_o     = dst_q;
    end

    AST_NO_SAME_CYCLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !iss_gnt_i); // R2
    AST_WAIT_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !iss_gnt_i); // R3
    AST_LAT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISSUED && cnt != LATW'(1)) |=> (st == ST_ISSUED)); // R6
endmodule

// File: rtl/sched_oldest.sv
module sched_oldest #(
    parameter int N = 8
) (
    input  logic [N-1:0]        req_i,
    input  logic [N-1:0][N-1:0] older_i,
    output logic [N-1:0]        gnt_o
);
    // older_i[j][i] = 1 when slot j was dispatched before slot i
    always_comb begin
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                blocked = blocked | (req_i[j] & older_i[j][i]);
            end
            gnt_o[i] = req_i[i] & ~blocked;
        end
    end
endmodule

// File: rtl/sched_rr.sv
module sched_rr #(
    parameter int NU = 2,
    parameter int UW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NU-1:0] busy_i,
    input  logic          take_i,
    output logic          avail_o,
    output logic [UW-1:0] unit_o
);
    logic [UW-1:0] ptr;

    always_comb begin
        avail_o = 1'b0;
        unit_o  = '0;
        for (int k = NU - 1; k >= 0; k--) begin
            if (!busy_i[(int'(ptr) + k) % NU]) begin
                avail_o = 1'b1;
                unit_o  = UW'((int'(ptr) + k) % NU);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (take_i) ptr <= (int'(unit_o) == NU - 1) ? '0 : unit_o + UW'(1);
    end

    AST_RR_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (NU > 1 && take_i) |=> (ptr != $past(unit_o))); // R5
endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import sched_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NUNITS = 2,
    parameter int TAGW   = 4,
    parameter int LATW   = 3,
    localparam int UW    = (NUNITS > 1) ? $clog2(NUNITS) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [TAGW-1:0]   disp_dst,
    input  logic [TAGW-1:0]   disp_src0_tag,
    input  logic              disp_src0_rdy,
    input  logic [TAGW-1:0]   disp_src1_tag,
    input  logic              disp_src1_rdy,
    input  logic [LATW-1:0]   disp_lat,
    output logic              full,
    input  logic              wake_valid,
    input  logic [TAGW-1:0]   wake_tag,
    input  logic [NUNITS-1:0] unit_busy,
    output logic              issue_valid,
    output logic [UW-1:0]     issue_unit,
    output logic [TAGW-1:0]   issue_tag,
    output logic              wb_valid,
    output logic [TAGW-1:0]   wb_tag,
    output logic [CW-1:0]     occupancy,
    output logic [CW-1:0]     inflight
);
    logic [DEPTH-1:0]            used_v, exec_v, iss_req, wb_req;
    logic [DEPTH-1:0]            alloc, iss_pick, iss_gnt, wb_gnt;
    logic [TAGW-1:0]             dst_a [DEPTH];
    logic [DEPTH-1:0][DEPTH-1:0] older;
    logic                        unit_avail;

    // lowest free slot takes the dispatch
    always_comb begin
        logic found;
        found = 1'b0;
        alloc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!used_v[i] && !found) begin
                alloc[i] = disp_valid;
                found    = 1'b1;
            end
        end
    end

    assign full = &used_v;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            sched_slot #(.TAGW(TAGW), .LATW(LATW)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_i    (alloc[g]),
                .a_dst_i    (disp_dst),
                .a_s0_tag_i (disp_src0_tag),
                .a_s0_rdy_i (disp_src0_rdy),
                .a_s1_tag_i (disp_src1_tag),
                .a_s1_rdy_i (disp_src1_rdy),
                .a_lat_i    (disp_lat),
                .wk_v_i     (wake_valid),
                .wk_tag_i   (wake_tag),
                .bc_v_i     (wb_valid),
                .bc_tag_i   (wb_tag),
                .iss_gnt_i  (iss_gnt[g]),
                .wb_gnt_i   (wb_gnt[g]),
                .used_o     (used_v[g]),
                .exec_o     (exec_v[g]),
                .iss_req_o  (iss_req[g]),
                .wb_req_o   (wb_req[g]),
                .dst_o      (dst_a[g])
            );
        end
    endgenerate

    // age matrix: a new slot is younger than every occupied slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int n = 0; n < DEPTH; n++) begin
                if (alloc[n]) begin
                    for (int k = 0; k < DEPTH; k++) begin
                        older[k][n] <= used_v[k];
                        older[n][k] <= 1'b0;
                    end
                end
            end
        end
    end

    sched_oldest #(.N(DEPTH)) u_iss_pick (
        .req_i   (iss_req),
        .older_i (older),
        .gnt_o   (iss_pick)
    );

    sched_oldest #(.N(DEPTH)) u_wb_pick (
        .req_i   (wb_req),
        .older_i (older),
        .gnt_o   (wb_gnt)
    );

    sched_rr #(.NU(NUNITS), .UW(UW)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (unit_busy),
        .take_i  (issue_valid),
        .avail_o (unit_avail),
        .unit_o  (issue_unit)
    );

    assign iss_gnt     = unit_avail ? iss_pick : '0;
    assign issue_valid = unit_avail && (|iss_req);
    assign wb_valid    = |wb_req;

    always_comb begin
        issue_tag = '0;
        wb_tag    = '0;
        occupancy = '0;
        inflight  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (iss_gnt[i]) issue_tag = issue_tag | dst_a[i];
            if (wb_gnt[i])  wb_tag    = wb_tag | dst_a[i];
            occupancy = occupancy + CW'(used_v[i]);
            inflight  = inflight + CW'(exec_v[i]);
        end
    end

    AST_ISSUE_UNIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !unit_busy[issue_unit]); // R5
    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_gnt)); // R5
    AST_ONE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_gnt)); // R7
    AST_WB_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (inflight != '0)); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !wb_valid) |=> full); // R8
    AST_INFLIGHT_LE_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= occupancy); // R9
endmodule

// File: tb/sim_issue_sched.sv
`timescale 1ns/1ps
module sim_issue_sched;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       disp_valid;
    logic [3:0] disp_dst, disp_src0_tag, disp_src1_tag;
    logic       disp_src0_rdy, disp_src1_rdy;
    logic [2:0] disp_lat;
    logic       full;
    logic       wake_valid;
    logic [3:0] wake_tag;
    logic [1:0] unit_busy;
    logic       issue_valid;
    logic [0:0] issue_unit;
    logic [3:0] issue_tag;
    logic       wb_valid;
    logic [3:0] wb_tag;
    logic [3:0] occupancy, inflight;

    int n_chk = 0;
    int n_fail = 0;
    int exp_rr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    issue_sched u0 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
        .disp_lat(disp_lat), .full(full), .wake_valid(wake_valid), .wake_tag(wake_tag),
        .unit_busy(unit_busy), .issue_valid(issue_valid), .issue_unit(issue_unit),
        .issue_tag(issue_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .occupancy(occupancy), .inflight(inflight)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic disp(input int dst, input int t0, input bit r0,
                        input int t1, input bit r1, input int lat);
        disp_valid    = 1'b1;
        disp_dst      = 4'(dst);
        disp_src0_tag = 4'(t0);
        disp_src0_rdy = r0;
        disp_src1_tag = 4'(t1);
        disp_src1_rdy = r1;
        disp_lat      = 3'(lat);
    endtask

    task automatic quiet;
        disp_valid = 1'b0;
        wake_valid = 1'b0;
    endtask

    function automatic int pick_unit(input logic [1:0] busy);
        for (int k = 0; k < 2; k++) begin
            if (!busy[(exp_rr + k) % 2]) return (exp_rr + k) % 2;
        end
        return -1;
    endfunction

    task automatic obs_issue(input int tag, input string req);
        int u;
        u = pick_unit(unit_busy);
        chk({req, " issue_valid"}, int'(issue_valid), 1);
        chk({req, " issue_tag"}, int'(issue_tag), tag);
        chk({req, " issue_unit"}, int'(issue_unit), u);
        if (u >= 0) exp_rr = (u + 1) % 2;
    endtask

    task automatic drain;
        for (int i = 0; i < 30; i++) begin
            if (occupancy == 0) break;
            tick();
        end
        chk("R9 drained occupancy", int'(occupancy), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        quiet();
        disp_dst = '0; disp_src0_tag = '0; disp_src1_tag = '0;
        disp_src0_rdy = 1'b0; disp_src1_rdy = 1'b0; disp_lat = '0;
        wake_tag = '0; unit_busy = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 full", int'(full), 0);
        chk("R1 issue_valid", int'(issue_valid), 0);
        chk("R1 wb_valid", int'(wb_valid), 0);
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 inflight", int'(inflight), 0);

        // R2 / R6: latency sweep over every encodable latency
        for (int lat = 0; lat < 8; lat++) begin
            int n;
            int exp_l;
            exp_l = (lat == 0) ? 1 : lat;
            disp(1, 0, 1'b1, 0, 1'b1, lat);
            #1;
            chk("R2 no issue in dispatch cycle", int'(issue_valid), 0);
            tick();
            quiet();
            obs_issue(1, "R2");
            n = 0;
            do begin
                tick();
                n++;
                if (n == 1) begin
                    chk("R9 inflight while executing", int'(inflight), 1);
                    chk("R9 occupancy while executing", int'(occupancy), 1);
                end
            end while (!wb_valid && n < 20);
            chk("R6 cycles issue to writeback", n, exp_l);
            chk("R6 wb_tag", int'(wb_tag), 1);
            tick();
            chk("R6 slot freed after writeback", int'(occupancy), 0);
        end

        // R3: external wakeup, non-matching tag ignored
        disp(2, 5, 1'b0, 0, 1'b1, 1);
        tick();
        quiet();
        for (int i = 0; i < 3; i++) begin
            chk("R3 waiting entry not issued", int'(issue_valid), 0);
            tick();
        end
        wake_valid = 1'b1; wake_tag = 4'd6;
        tick();
        chk("R3 non-matching wake ignored", int'(issue_valid), 0);
        wake_tag = 4'd5;
        tick();
        quiet();
        obs_issue(2, "R3 external wake");
        drain();

        // R3: wakeup in the dispatch cycle, second source still missing
        disp(3, 7, 1'b0, 8, 1'b0, 1);
        wake_valid = 1'b1; wake_tag = 4'd7;
        tick();
        quiet();
        chk("R3 one source still missing", int'(issue_valid), 0);
        wake_valid = 1'b1; wake_tag = 4'd8;
        tick();
        quiet();
        obs_issue(3, "R3 bypass then wake");
        drain();

        // R3: write-back broadcast wakes a dependent
        disp(6, 0, 1'b1, 0, 1'b1, 1);
        tick();
        disp(7, 6, 1'b0, 0, 1'b1, 1);
        obs_issue(6, "R3 producer");
        tick();
        quiet();
        chk("R3 producer writeback", int'(wb_valid), 1);
        chk("R3 producer wb_tag", int'(wb_tag), 6);
        chk("R3 dependent still waiting", int'(issue_valid), 0);
        tick();
        obs_issue(7, "R3 broadcast wake");
        drain();

        // R4 / R5: younger ready passes older waiting; all-busy stalls
        unit_busy = 2'b11;
        disp(3, 9, 1'b0, 0, 1'b1, 1);
        tick();
        disp(4, 0, 1'b1, 0, 1'b1, 1);
        tick();
        chk("R5 no issue while all units busy", int'(issue_valid), 0);
        disp(5, 0, 1'b1, 0, 1'b1, 1);
        tick();
        quiet();
        unit_busy = 2'b00;
        #1;
        obs_issue(4, "R4 younger ready passes waiting");
        tick();
        obs_issue(5, "R4");
        wake_valid = 1'b1; wake_tag = 4'd9;
        tick();
        quiet();
        obs_issue(3, "R4 woken older");
        tick();
        drain();

        // R4 / R5: oldest-first among ready, single busy units
        unit_busy = 2'b11;
        disp(10, 0, 1'b1, 0, 1'b1, 1);
        tick();
        disp(11, 0, 1'b1, 0, 1'b1, 1);
        tick();
        disp(12, 0, 1'b1, 0, 1'b1, 1);
        tick();
        quiet();
        unit_busy = 2'b01;
        #1;
        obs_issue(10, "R4 R5 unit0 busy");
        tick();
        unit_busy = 2'b10;
        #1;
        obs_issue(11, "R4 R5 unit1 busy");
        tick();
        unit_busy = 2'b00;
        #1;
        obs_issue(12, "R4 R5 both free");
        tick();
        drain();

        // R8 / R9: fill all slots, extra dispatch dropped
        unit_busy = 2'b11;
        for (int k = 0; k < 8; k++) begin
            disp(k, 0, 1'b1, 0, 1'b1, 1);
            tick();
            chk("R9 occupancy while filling", int'(occupancy), k + 1);
        end
        chk("R8 full when all slots used", int'(full), 1);
        disp(14, 0, 1'b1, 0, 1'b1, 1);
        tick();
        quiet();
        chk("R8 dispatch while full dropped", int'(occupancy), 8);
        unit_busy = 2'b00;
        #1;
        for (int k = 0; k < 8; k++) begin
            obs_issue(k, "R8 R4 drain order");
            tick();
        end
        chk("R8 dropped micro-op never issues", int'(issue_valid), 0);
        drain();
        chk("R8 full cleared", int'(full), 0);

        // R7: two completions in one cycle
        unit_busy = 2'b11;
        disp(1, 0, 1'b1, 0, 1'b1, 2);
        tick();
        disp(2, 0, 1'b1, 0, 1'b1, 1);
        tick();
        quiet();
        unit_busy = 2'b00;
        #1;
        obs_issue(1, "R7");
        tick();
        obs_issue(2, "R7");
        tick();
        chk("R7 first writeback valid", int'(wb_valid), 1);
        chk("R7 oldest wins port", int'(wb_tag), 1);
        tick();
        chk("R7 loser follows", int'(wb_valid), 1);
        chk("R7 loser tag", int'(wb_tag), 2);
        tick();
        chk("R7 no further writeback", int'(wb_valid), 0);
        chk("R9 empty after collision", int'(occupancy), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule